// File: doc/BRIEF.md
# Serial Port Transfer Status Register

This block holds the status word of a clocked synchronous serial port that can act as clock master or clock slave and move data in one of three directions: transmit only, receive only, or transmit and receive together. It keeps a busy flag that shows a transfer is being prepared or is under way. It also keeps three sticky error flags: overrun, parity and data-consistency. The shift engine, the baud timer and the serial pins sit outside the block. The block only takes event pulses from them and turns those pulses into status state.

The event that raises the busy flag depends on role and direction. In any direction that transmits, a write to the transmit data register (word or halfword access) raises it. In master receive-only operation, a read of the receive data register raises it. In slave receive-only operation, a serial-clock edge raises it. In every case the flag drops on the first half-period tick after the last clock edge of a transfer has been captured.

Software may write the error flags only while the port is powered down. Reads are free of side effects.

Top module: `sts_xfer_status`

## Requirements
- R1: After reset, `rd_data` reads 0x0000_0010.
- R2: Bit 4 of `rd_data` always reads 1, and bits 2, 5, 6 and 8 up to the top always read 0. A bus write never changes these bits, and never changes the busy flag at bit 7.
- R3: When `dir_mode` is 0 (transmit only), 2 or 3 (both 2 and 3 mean transmit/receive), a pulse on `tx_wr_word` or `tx_wr_half` sets bit 7 in the next cycle. This holds for either value of `role_slave`.
- R4: When `dir_mode` is 1 (receive only) and `role_slave` is 0, a pulse on `rx_rd` sets bit 7 in the next cycle.
- R5: When `dir_mode` is 1 and `role_slave` is 1, a pulse on `sck_edge` sets bit 7 in the next cycle.
- R6: An event that is not the set event of the current role and direction leaves bit 7 at 0. Examples are a transmit write in receive-only mode, a receive read in the slave role or in a transmitting mode, and a clock edge outside slave receive-only operation.
- R7: A cycle with `sck_edge` and `sck_last` both high arms a pending clear. Bit 7 drops in the cycle after the first `half_tick` that comes strictly after the arming cycle. Bit 7 never drops in any other way except reset.
- R8: A set event wins over a clear in the same cycle, so bit 7 stays 1. That `half_tick` still uses up the pending clear.
- R9: A one-cycle pulse on `err_ovr`, `err_par` or `err_dce` sets bit 0, 1 or 3 respectively. The bit stays set with no further events.
- R10: While `pwr_en` is 0, a bus write loads `wr_data` bits 0, 1 and 3 into the three error flags. While `pwr_en` is 1, a bus write leaves them unchanged.
- R11: An error event in the same cycle as a bus write of 0 to that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| role_slave | input | 1 | 1 = port is clock slave, 0 = clock master |
| dir_mode | input | 2 | 0 transmit only, 1 receive only, 2/3 transmit and receive |
| pwr_en | input | 1 | Port power enable; error flags writable only while 0 |
| tx_wr_word | input | 1 | Word write to transmit data register |
| tx_wr_half | input | 1 | Halfword write to transmit data register |
| rx_rd | input | 1 | Read of receive data register |
| sck_edge | input | 1 | Serial clock edge pulse from the shift engine |
| sck_last | input | 1 | Marks the current `sck_edge` as the last of the transfer |
| half_tick | input | 1 | Half serial-clock period tick from the baud timer |
| err_ovr | input | 1 | Overrun event pulse |
| err_par | input | 1 | Parity error event pulse |
| err_dce | input | 1 | Data-consistency error event pulse |
| bus_wr | input | 1 | Status register write strobe |
| wr_data | input | 32 | Status register write data |
| rd_data | output | 32 | Status register read value |

## Verification
The bench sweeps every role, every direction code and every busy-setting event, including the spare direction code 3. A decoder that mixed up role and direction would raise busy on the wrong strobe or miss the right one. The bench puts a `half_tick` in the same cycle as the last edge, which catches a design that clears the flag at once instead of waiting for a later tick. It also places a set event on a clearing tick, where a clear-first design would drop busy between back-to-back transfers. For the error flags, the bench tries writes under power, writes of 1 and 0 while powered down, and an event that collides with a clearing write. A loose write gate or a write-first priority shows up as a wrong flag value in these cases.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam int BIT_OVR  = 0;
    localparam int BIT_PAR  = 1;
    localparam int BIT_DCE  = 3;
    localparam int BIT_FIX  = 4;
    localparam int BIT_BUSY = 7;
    localparam int NUM_ERR  = 3;

    localparam logic [1:0] DIR_TX = 2'd0;
    localparam logic [1:0] DIR_RX = 2'd1;

    typedef struct packed {
        logic busy;
        logic pend;
    } busy_state_t;
endpackage

// File: rtl/sts_busy_track.sv
module sts_busy_track
    import sts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       role_slave,
    input  logic [1:0] dir_mode,
    input  logic       tx_wr_word,
    input  logic       tx_wr_half,
    input  logic       rx_rd,
    input  logic       sck_edge,
    input  logic       sck_last,
    input  logic       half_tick,
    output logic       busy
);
    busy_state_t st_d, st_q;
    logic rx_only, set_ev, clr_ev;

    always_comb begin
        rx_only = (dir_mode == DIR_RX);
        set_ev  = (!rx_only && (tx_wr_word || tx_wr_half))
                || (rx_only && !role_slave && rx_rd)
                || (rx_only &&  role_slave && sck_edge);
        clr_ev  = st_q.pend && half_tick;

        st_d = st_q;
        // a freshly captured last edge arms; a tick consumes the armed clear
        if (sck_edge && sck_last) st_d.pend = 1'b1;
        else if (half_tick)       st_d.pend = 1'b0;
        // set has priority over clear
        st_d.busy = set_ev || (st_q.busy && !clr_ev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/sts_err_bank.sv
module sts_err_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_en,
    input  logic         bus_wr,
    input  logic [N-1:0] wr_val,
    input  logic [N-1:0] ev,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] flag;
    } err_state_t;

    err_state_t st_d, st_q;
    logic [N-1:0] nxt;
    logic         wr_ok;

    assign wr_ok = bus_wr && !pwr_en;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // event wins over a software write
        assign nxt[i] = (wr_ok ? wr_val[i] : st_q.flag[i]) | ev[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flag;
endmodule

// File: rtl/sts_read_view.sv
module sts_read_view
    import sts_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             busy,
    input  logic             f_ovr,
    input  logic             f_par,
    input  logic             f_dce,
    output logic [REG_W-1:0] rd_data
);
    always_comb begin
        rd_data           = '0;
        rd_data[BIT_FIX]  = 1'b1;
        rd_data[BIT_BUSY] = busy;
        rd_data[BIT_DCE]  = f_dce;
        rd_data[BIT_PAR]  = f_par;
        rd_data[BIT_OVR]  = f_ovr;
    end
endmodule

// File: rtl/sts_xfer_status.sv
module sts_xfer_status
    import sts_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             role_slave,
    input  logic [1:0]       dir_mode,
    input  logic             pwr_en,
    input  logic             tx_wr_word,
    input  logic             tx_wr_half,
    input  logic             rx_rd,
    input  logic             sck_edge,
    input  logic             sck_last,
    input  logic             half_tick,
    input  logic             err_ovr,
    input  logic             err_par,
    input  logic             err_dce,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    logic               busy;
    logic [NUM_ERR-1:0] flags;
    logic               unused_wdata;

    // bits other than the writable error flags are discarded
    assign unused_wdata = ^{wr_data[REG_W-1:BIT_FIX], wr_data[2]};

    sts_busy_track i_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .role_slave (role_slave),
        .dir_mode   (dir_mode),
        .tx_wr_word (tx_wr_word),
        .tx_wr_half (tx_wr_half),
        .rx_rd      (rx_rd),
        .sck_edge   (sck_edge),
        .sck_last   (sck_last),
        .half_tick  (half_tick),
        .busy       (busy)
    );

    sts_err_bank #(.N(NUM_ERR)) i_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_en (pwr_en),
        .bus_wr (bus_wr),
        .wr_val ({wr_data[BIT_DCE], wr_data[BIT_PAR], wr_data[BIT_OVR]}),
        .ev     ({err_dce, err_par, err_ovr}),
        .flags  (flags)
    );

    sts_read_view #(.REG_W(REG_W)) i_view (
        .busy    (busy),
        .f_ovr   (flags[0]),
        .f_par   (flags[1]),
        .f_dce   (flags[2]),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/sts_xfer_status_chk.sv
module sts_xfer_status_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             role_slave,
    input logic [1:0]       dir_mode,
    input logic             pwr_en,
    input logic             tx_wr_word,
    input logic             tx_wr_half,
    input logic             sck_edge,
    input logic             half_tick,
    input logic             err_ovr,
    input logic             err_par,
    input logic             err_dce,
    input logic             bus_wr,
    input logic [REG_W-1:0] rd_data
);
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:8] == '0 && rd_data[6:4] == 3'b001 && rd_data[2] == 1'b0);

    a_r3_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode != 2'd1 && (tx_wr_word || tx_wr_half)) |=> rd_data[7]);

    a_r5_slave_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode == 2'd1 && role_slave && sck_edge) |=> rd_data[7]);

    a_r7_drop_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !half_tick) |=> rd_data[7]);

    a_r9_par_event: assert property (@(posedge clk) disable iff (!rst_n)
        err_par |=> rd_data[1]);

    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !(bus_wr && !pwr_en)) |=> rd_data[0]);

    a_r10_locked_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !err_ovr && !err_par && !err_dce) |=> $stable({rd_data[3], rd_data[1:0]}));

    a_r11_event_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        (err_dce && bus_wr) |=> rd_data[3]);
endmodule

bind sts_xfer_status sts_xfer_status_chk #(.REG_W(REG_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_slave (role_slave),
    .dir_mode   (dir_mode),
    .pwr_en     (pwr_en),
    .tx_wr_word (tx_wr_word),
    .tx_wr_half (tx_wr_half),
    .sck_edge   (sck_edge),
    .half_tick  (half_tick),
    .err_ovr    (err_ovr),
    .err_par    (err_par),
    .err_dce    (err_dce),
    .bus_wr     (bus_wr),
    .rd_data    (rd_data)
);

// File: tb/test_sts_xfer_status.sv
module test_sts_xfer_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        role_slave = 1'b0;
    logic [1:0]  dir_mode = 2'd0;
    logic        pwr_en = 1'b0;
    logic        tx_wr_word = 1'b0, tx_wr_half = 1'b0, rx_rd = 1'b0;
    logic        sck_edge = 1'b0, sck_last = 1'b0, half_tick = 1'b0;
    logic        err_ovr = 1'b0, err_par = 1'b0, err_dce = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sts_xfer_status i_sts_xfer_status (.*);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive on the falling edge; after return the posedge has taken the inputs
    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        tx_wr_word = 0; tx_wr_half = 0; rx_rd = 0; sck_edge = 0; sck_last = 0;
        half_tick = 0; err_ovr = 0; err_par = 0; err_dce = 0; bus_wr = 0; wr_data = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        step();
        rst_n = 1;
        step();
    endtask

    function automatic logic [31:0] word(input logic b, input logic [2:0] e);
        return {24'd0, b, 3'b001, e[2], 1'b0, e[1], e[0]};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset value", rd_data, 32'h0000_0010);

        // R3 R4 R5 R6: sweep role x direction x event
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 4; m++) begin
                for (int ev = 0; ev < 4; ev++) begin
                    logic exp_b;
                    do_reset();
                    role_slave = r[0];
                    dir_mode = m[1:0];
                    case (ev)
                        0: tx_wr_word = 1;
                        1: tx_wr_half = 1;
                        2: rx_rd = 1;
                        default: sck_edge = 1;
                    endcase
                    if (m != 1) exp_b = (ev < 2);
                    else if (r == 0) exp_b = (ev == 2);
                    else exp_b = (ev == 3);
                    step();
                    idle_inputs();
                    check(exp_b ? "R3/R4/R5 set event" : "R6 non-set event",
                          rd_data, word(exp_b, 3'b000));
                end
            end
        end

        // R7: tick in the arming cycle does not clear
        do_reset();
        role_slave = 0; dir_mode = 2'd0;
        tx_wr_word = 1; step(); idle_inputs();
        sck_edge = 1; sck_last = 1; half_tick = 1; step(); idle_inputs();
        check("R7 no clear on arming tick", rd_data, word(1, 3'b000));
        step();
        check("R7 no clear without tick", rd_data, word(1, 3'b000));
        sck_edge = 1; step(); idle_inputs();
        check("R7 plain edge no clear", rd_data, word(1, 3'b000));
        half_tick = 1; step(); idle_inputs();
        check("R7 clear on later tick", rd_data, word(0, 3'b000));

        // R8: set wins, and the tick consumes the pending clear
        tx_wr_half = 1; step(); idle_inputs();
        sck_edge = 1; sck_last = 1; step(); idle_inputs();
        tx_wr_word = 1; half_tick = 1; step(); idle_inputs();
        check("R8 set beats clear", rd_data, word(1, 3'b000));
        half_tick = 1; step(); idle_inputs();
        check("R8 pending consumed", rd_data, word(1, 3'b000));

        // R2: bus write of all ones touches only the error flags
        do_reset();
        pwr_en = 0; bus_wr = 1; wr_data = '1; step(); idle_inputs();
        check("R2 fixed bits on write", rd_data, word(0, 3'b111));
        bus_wr = 1; wr_data = '0; step(); idle_inputs();
        check("R10 powered-down clear", rd_data, word(0, 3'b000));

        // R9 R10 R11 per flag
        for (int k = 0; k < 3; k++) begin
            logic [2:0] m3 = 3'b001 << k;
            logic [31:0] wv = (k == 0) ? 32'h1 : (k == 1) ? 32'h2 : 32'h8;
            do_reset();
            pwr_en = 1;
            err_ovr = m3[0]; err_par = m3[1]; err_dce = m3[2]; step(); idle_inputs();
            step(); step();
            check("R9 sticky event", rd_data, word(0, m3));
            bus_wr = 1; wr_data = '0; step(); idle_inputs();
            check("R10 write ignored when powered", rd_data, word(0, m3));
            pwr_en = 0;
            bus_wr = 1; wr_data = '0; step(); idle_inputs();
            check("R10 write clears when off", rd_data, word(0, 3'b000));
            bus_wr = 1; wr_data = wv; step(); idle_inputs();
            check("R10 write sets when off", rd_data, word(0, m3));
            bus_wr = 1; wr_data = '0;
            err_ovr = m3[0]; err_par = m3[1]; err_dce = m3[2]; step(); idle_inputs();
            check("R11 event beats clearing write", rd_data, word(0, m3));
            pwr_en = 1; bus_wr = 1; wr_data = '1; step(); idle_inputs();
            check("R10 set ignored when powered", rd_data, word(0, m3));
            pwr_en = 0;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule